// File: doc/BRIEF.md
# Acquisition Trigger Conditioner

This block decides which trigger requests may start an acquisition. Two sources feed it. The first is a one-cycle pulse from the external timing system. The second is a one-cycle strobe that software raises through the register interface.

The external pulse has two controls that the software strobe does not have:
- a disable control, which drops the pulse when it arrives;
- a programmable delay of zero to seven clock cycles.

When a request (external or software) reaches the gate, the gate refuses it in three cases: the module is busy, the data FIFO is full, or the operating mode is the one that starts on the event header alone.

Each request the gate accepts produces three results:
- a single start pulse;
- a clear pulse for the FIFO word counter;
- an increment of a 12-bit trigger count. The acquisition logic can also write this count into the event data stream.

Top module: `trig_gate_top`

## Requirements
- R1: With the disable input low, an external pulse sampled at clock edge k with delay field d (0..7) produces, when accepted, `start_o` high for exactly the one cycle that follows edge k+d. The delay field must be held steady while a pulse is in flight.
- R2: An external pulse sampled while `ext_disable_i` is 1 is dropped for good. It produces no start, even if the disable input is cleared before the pulse's delay has elapsed.
- R3: A software strobe sampled at edge k produces, when accepted, `start_o` high in the cycle after edge k. Neither the delay field nor the disable input affects it.
- R4: Busy and FIFO-full are evaluated in the cycle in which a request reaches the gate. For a delayed external pulse, that is the cycle in which it leaves the delay line. If `busy_i` or `fifo_full_i` is 1 in that cycle, the request is discarded.
- R5: The mode field selects acceptance. Mode value 2'b10 (start on header only) discards every request. Mode values 2'b00, 2'b01 and 2'b11 accept them.
- R6: Each accepted request raises `trig_count_o` by one. The new value is visible in the same cycle as the start pulse. In all other cycles the count holds.
- R7: The trigger count wraps from 12'hFFF to 12'h000.
- R8: An external pulse leaving the delay line in the same cycle as a software strobe counts as one request: one start pulse and one increment.
- R9: `fifo_cnt_clr_o` pulses in exactly the cycles in which `start_o` is high.
- R10: Reset (active-low, asynchronous) clears the count, the start and clear pulses, and any external pulse still in the delay line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_trig_i | input | 1 | External trigger pulse, one cycle |
| sw_trig_i | input | 1 | Software trigger strobe, one cycle |
| ext_disable_i | input | 1 | 1 drops incoming external pulses |
| delay_sel_i | input | 3 | External trigger delay in cycles |
| mode_i | input | 2 | Operating mode; 2'b10 discards triggers |
| busy_i | input | 1 | Acquisition in progress |
| fifo_full_i | input | 1 | Data FIFO full |
| start_o | output | 1 | One-cycle acquisition start |
| fifo_cnt_clr_o | output | 1 | One-cycle clear for the FIFO word counter |
| trig_count_o | output | 12 | Accepted-trigger count |

## Verification
The checker watches four things on every cycle:
- A start pulse never follows a cycle with busy, FIFO-full or the header-only mode.
- A software strobe that meets the acceptance conditions always produces a start pulse.
- The count steps by exactly one, with wrap, on each start.
- The count holds when there is no start.

Some behaviours only the bench scenarios can show, because they depend on history that the checker does not rebuild:
- the exact exit cycle of each delay setting;
- the permanent loss of a pulse that arrived while the disable input was set;
- the merge of coincident requests;
- the flushing of pulses still in flight when reset is applied.

// File: rtl/trig_pkg.sv
package trig_pkg;
    localparam int TRIG_DLY_W = 3;
    localparam int TRIG_CNT_W = 12;

    typedef enum logic [1:0] {
        MODE_STREAM   = 2'b00,
        MODE_TRIG_HDR = 2'b01,
        MODE_HDR_ONLY = 2'b10,
        MODE_TRIG_WIN = 2'b11
    } acq_mode_e;
endpackage

// File: rtl/trig_delay_line.sv
module trig_delay_line #(
    parameter int DLY_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pulse_i,
    input  logic             drop_i,
    input  logic [DLY_W-1:0] sel_i,
    output logic             pulse_o
);
    localparam int DEPTH  = 1 << DLY_W;
    localparam int STAGES = DEPTH - 1;

    typedef struct packed {
        logic [STAGES-1:0] line;
    } dl_state_t;

    dl_state_t state_d, state_q;
    logic              entry;
    logic [DEPTH-1:0]  taps;

    // Disabled pulses never enter the line, so they cannot reappear later.
    assign entry   = pulse_i & ~drop_i;
    assign taps[0] = entry;

    genvar k;
    generate
        for (k = 1; k < DEPTH; k++) begin : g_tap
            assign taps[k] = state_q.line[k-1];
        end
    endgenerate

    always_comb begin
        state_d = state_q;
        if (STAGES > 1) begin
            state_d.line = {state_q.line[STAGES-2:0], entry};
        end else begin
            state_d.line = entry;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign pulse_o = taps[sel_i];
endmodule

// File: rtl/trig_qualifier.sv
module trig_qualifier
    import trig_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ext_req_i,
    input  logic       sw_req_i,
    input  logic [1:0] mode_i,
    input  logic       busy_i,
    input  logic       full_i,
    output logic       accept_o,
    output logic       start_o
);
    typedef struct packed {
        logic start;
    } q_state_t;

    q_state_t state_d, state_q;
    logic     req;
    logic     mode_ok;

    assign req     = ext_req_i | sw_req_i;   // coincident requests merge
    assign mode_ok = (acq_mode_e'(mode_i) != MODE_HDR_ONLY);

    always_comb begin
        state_d       = state_q;
        accept_o      = req & mode_ok & ~busy_i & ~full_i;
        state_d.start = accept_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign start_o = state_q.start;
endmodule

// File: rtl/trig_counter.sv
module trig_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    output logic [CNT_W-1:0] count_o
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
    } c_state_t;

    c_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (inc_i) begin
            state_d.count = state_q.count + 1'b1;   // natural wrap
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign count_o = state_q.count;
endmodule

// File: rtl/trig_gate_top.sv
module trig_gate_top
    import trig_pkg::*;
#(
    parameter int DLY_W = TRIG_DLY_W,
    parameter int CNT_W = TRIG_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_trig_i,
    input  logic             sw_trig_i,
    input  logic             ext_disable_i,
    input  logic [DLY_W-1:0] delay_sel_i,
    input  logic [1:0]       mode_i,
    input  logic             busy_i,
    input  logic             fifo_full_i,
    output logic             start_o,
    output logic             fifo_cnt_clr_o,
    output logic [CNT_W-1:0] trig_count_o
);
    logic ext_delayed;
    logic accept;

    trig_delay_line #(.DLY_W(DLY_W)) u_delay (
        .clk     (clk),
        .rst_n   (rst_n),
        .pulse_i (ext_trig_i),
        .drop_i  (ext_disable_i),
        .sel_i   (delay_sel_i),
        .pulse_o (ext_delayed)
    );

    trig_qualifier u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_req_i (ext_delayed),
        .sw_req_i  (sw_trig_i),
        .mode_i    (mode_i),
        .busy_i    (busy_i),
        .full_i    (fifo_full_i),
        .accept_o  (accept),
        .start_o   (start_o)
    );

    trig_counter #(.CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_i   (accept),
        .count_o (trig_count_o)
    );

    assign fifo_cnt_clr_o = start_o;
endmodule

// File: rtl/trig_gate_chk.sv
module trig_gate_chk #(
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sw_trig_i,
    input logic [1:0]       mode_i,
    input logic             busy_i,
    input logic             fifo_full_i,
    input logic             start_o,
    input logic [CNT_W-1:0] trig_count_o
);
    // R4: a start never follows a busy or full cycle
    a_r4_no_start_when_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> ($past(busy_i) == 1'b0 && $past(fifo_full_i) == 1'b0));

    // R5: header-only mode never yields a start
    a_r5_no_start_in_hdr_mode: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> ($past(mode_i) != 2'b10));

    // R3: an eligible software strobe always yields a start
    a_r3_sw_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_trig_i && !busy_i && !fifo_full_i && mode_i != 2'b10) |=> start_o);

    // R6 / R7: the count steps by one, with wrap, on each start
    a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> (trig_count_o == CNT_W'($past(trig_count_o) + 1'b1)));

    // R6: the count holds when there is no start
    a_r6_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !start_o |-> $stable(trig_count_o));
endmodule

bind trig_gate_top trig_gate_chk #(.CNT_W(CNT_W)) u_trig_gate_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sw_trig_i    (sw_trig_i),
    .mode_i       (mode_i),
    .busy_i       (busy_i),
    .fifo_full_i  (fifo_full_i),
    .start_o      (start_o),
    .trig_count_o (trig_count_o)
);

// File: tb/tb_trig_gate_top.sv
`timescale 1ns/1ps
module tb_trig_gate_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_trig_i = 1'b0;
    logic        sw_trig_i = 1'b0;
    logic        ext_disable_i = 1'b0;
    logic [2:0]  delay_sel_i = 3'd0;
    logic [1:0]  mode_i = 2'b00;
    logic        busy_i = 1'b0;
    logic        fifo_full_i = 1'b0;
    logic        start_o;
    logic        fifo_cnt_clr_o;
    logic [11:0] trig_count_o;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    logic [11:0] exp_cnt = 12'd0;
    bit arrive [0:16383];

    always #2 clk = ~clk;

    trig_gate_top dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .ext_trig_i     (ext_trig_i),
        .sw_trig_i      (sw_trig_i),
        .ext_disable_i  (ext_disable_i),
        .delay_sel_i    (delay_sel_i),
        .mode_i         (mode_i),
        .busy_i         (busy_i),
        .fifo_full_i    (fifo_full_i),
        .start_o        (start_o),
        .fifo_cnt_clr_o (fifo_cnt_clr_o),
        .trig_count_o   (trig_count_o)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)",
                     tag, what, act, exp, cyc);
        end
    endtask

    task automatic clear_model();
        for (int i = 0; i < 16384; i++) arrive[i] = 1'b0;
        exp_cnt = 12'd0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ext_trig_i = 1'b0;
        sw_trig_i = 1'b0;
        #1;
        chk(start_o == 1'b0, "R10", "start in reset", start_o, 0);
        chk(fifo_cnt_clr_o == 1'b0, "R10", "clr in reset", fifo_cnt_clr_o, 0);
        chk(trig_count_o == 12'd0, "R10", "count in reset", trig_count_o, 0);
        clear_model();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic step(input logic e, input logic s, input logic dis,
                        input logic [2:0] d, input logic [1:0] m,
                        input logic b, input logic f, input string tag);
        bit acc;
        @(negedge clk);
        ext_trig_i = e;
        sw_trig_i = s;
        ext_disable_i = dis;
        delay_sel_i = d;
        mode_i = m;
        busy_i = b;
        fifo_full_i = f;
        if (e && !dis) arrive[cyc + int'(d)] = 1'b1;
        acc = (arrive[cyc] || s) && !b && !f && (m != 2'b10);
        if (acc) exp_cnt = exp_cnt + 12'd1;
        @(posedge clk);
        #1;
        chk(start_o == acc, tag, "start", start_o, acc);
        chk(fifo_cnt_clr_o == acc, "R9", "fifo clear", fifo_cnt_clr_o, acc);
        chk(trig_count_o == exp_cnt, tag, "count", trig_count_o, exp_cnt);
        cyc++;
    endtask

    task automatic idle(input int n, input logic [2:0] d, input string tag);
        for (int i = 0; i < n; i++) step(0, 0, 0, d, 2'b00, 0, 0, tag);
    endtask

    initial begin
        #800000;
        failures++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        clear_model();
        do_reset();
        idle(2, 0, "R10");

        // R1: every delay setting
        for (int d = 0; d < 8; d++) begin
            step(1, 0, 0, 3'(d), 2'b00, 0, 0, "R1");
            idle(9, 3'(d), "R1");
        end
        // R3: software strobe ignores delay and disable
        for (int d = 0; d < 8; d++) begin
            step(0, 1, 1, 3'(d), 2'b01, 0, 0, "R3");
            idle(2, 3'(d), "R3");
        end
        // R2: disabled pulses stay lost after the disable clears
        for (int d = 0; d < 8; d++) begin
            step(1, 0, 1, 3'(d), 2'b00, 0, 0, "R2");
            idle(9, 3'(d), "R2");
        end
        // R4: busy or full at the exit cycle blocks; during flight it does not
        step(1, 0, 0, 3'd3, 2'b00, 0, 0, "R4");
        step(0, 0, 0, 3'd3, 2'b00, 1, 0, "R4");
        step(0, 0, 0, 3'd3, 2'b00, 1, 1, "R4");
        step(0, 0, 0, 3'd3, 2'b00, 0, 0, "R4");
        idle(4, 3'd3, "R4");
        step(1, 0, 0, 3'd3, 2'b00, 0, 0, "R4");
        idle(2, 3'd3, "R4");
        step(0, 0, 0, 3'd3, 2'b00, 1, 0, "R4");
        idle(4, 3'd3, "R4");
        step(1, 0, 0, 3'd5, 2'b00, 0, 0, "R4");
        idle(4, 3'd5, "R4");
        step(0, 0, 0, 3'd5, 2'b00, 0, 1, "R4");
        idle(4, 3'd5, "R4");
        // R5: every mode, both sources
        for (int m = 0; m < 4; m++) begin
            step(0, 1, 0, 3'd2, 2'(m), 0, 0, "R5");
            step(1, 0, 0, 3'd2, 2'(m), 0, 0, "R5");
            step(0, 0, 0, 3'd2, 2'(m), 0, 0, "R5");
            step(0, 0, 0, 3'd2, 2'(m), 0, 0, "R5");
            idle(3, 3'd2, "R5");
        end
        // R8: coincident requests merge
        step(1, 1, 0, 3'd0, 2'b11, 0, 0, "R8");
        idle(2, 3'd0, "R8");
        step(1, 0, 0, 3'd2, 2'b00, 0, 0, "R8");
        step(0, 0, 0, 3'd2, 2'b00, 0, 0, "R8");
        step(0, 1, 0, 3'd2, 2'b00, 0, 0, "R8");
        idle(3, 3'd2, "R8");
        // R6: sweep of all gating combinations with undelayed external pulses
        for (int v = 0; v < 64; v++) begin
            step(v[0], v[1], v[2], 3'd0, 2'(v[4:3]), v[5], 1'b0, "R6");
            step(0, v[1], 0, 3'd0, 2'(v[4:3]), 1'b0, v[5], "R6");
        end
        idle(2, 3'd0, "R6");
        // R10: reset flushes a pulse in flight
        step(1, 0, 0, 3'd7, 2'b00, 0, 0, "R10");
        idle(2, 3'd7, "R10");
        do_reset();
        idle(9, 3'd7, "R10");
        // R7: wrap of the count
        for (int i = 0; i < 4100; i++) step(0, 1, 0, 3'd0, 2'b00, 0, 0, "R7");
        idle(2, 3'd0, "R7");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule